// File: doc/BRIEF.md
# Work-Load Command Frame Controller

This block holds one work-load descriptor for a small memory-exercising engine and arbitrates who may change it. Software fills in the descriptor words through a simple word-addressed register port: range start, inclusive range end, stride, seed, substream identifier, completion-interrupt address and interrupt data. It then writes an operation code to the command word. The controller checks the whole descriptor in the same cycle as that write. A bad descriptor is refused at once and reads back as misconfigured. A good one starts the address-sequencing datapath with a one-cycle start pulse. From then on the frame refuses every write until the job is over.

The same 32-bit word carries both the command and the status. While a job runs, it shows the running operation code. When the datapath reports completion, the word becomes halted, or error if a downstream access aborted. If the interrupt address is nonzero, a completion interrupt is first requested, held until it is acknowledged, and only after that is the final status published. An aborted interrupt sets a sticky flag in the user control word. The controller also counts the transactions that the datapath launches and returns during the current job.

Top module: `cmdframe_ctrl`

## Requirements
- R1: After reset the command word reads 1 (halted), and the user control word and both transaction counters read 0.
- R2: Writing a command value from 5 to 0xFFFFFFFD makes the command word read 0xFFFFFFFE (misconfigured) in the cycle after the write edge. No start pulse follows and no interrupt is requested.
- R3: For the operation codes 2 (copy), 3 (random fill) and 4 (64-bit sum), a stride of 1 or a nonzero multiple of 8 is accepted. A stride of 0 or any other value is rejected as misconfigured.
- R4: A command is rejected as misconfigured when the start address with its low 3 bits cleared is 0 and the end address with its low 3 bits set is all ones.
- R5: For code 4, a start address whose bits [2:0] are not 000, or an end address whose bits [2:0] are not 111, makes the command misconfigured.
- R6: The substream word (word address 14) is accepted when it is 0xFFFFFFFF (no substream) or fits in 20 bits. Any other value rejects the command as misconfigured.
- R7: An accepted command makes the command word read the operation code. In the cycle after the write edge it raises `job_start` for exactly one cycle, with the descriptor on the job outputs, and it clears both counters.
- R8: While a job is running or its interrupt is pending, writes to any word of the frame are ignored, including the command word.
- R9: A `job_done` pulse with the interrupt address at 0 makes the command word read 1 if `job_abort` was low and 0xFFFFFFFF if it was high, in the next cycle.
- R10: With a nonzero interrupt address, `job_done` raises `irq_req` in the next cycle, together with the interrupt address and data. The request holds until `irq_ack`, and the command word keeps the operation code until that point. After the acknowledge the final status appears. An `irq_abort` during the acknowledge sets bit 0 of the user control word (word address 1), and that bit stays set.
- R11: Writing 0 (no frame) or 1 to the command word while the frame is writable makes it read 1.
- R12: Pulses on `txn_launch` and `txn_return` during a job increment the words at addresses 2 and 3, which can be read at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Word address of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Word address of the read |
| reg_rdata | output | 32 | Read data, combinational from reg_raddr |
| job_start | output | 1 | One-cycle pulse starting the datapath |
| job_op | output | 3 | Operation code of the running job |
| job_begin | output | 64 | Range start address |
| job_end | output | 64 | Inclusive range end address |
| job_stride | output | 64 | Stride |
| job_seed | output | 32 | Ordering and data seed |
| job_substream | output | 32 | Substream identifier |
| txn_launch | input | 1 | Datapath launched one transaction |
| txn_return | input | 1 | One transaction returned |
| job_done | input | 1 | Job has finished |
| job_abort | input | 1 | Qualifies job_done: a downstream access aborted |
| irq_req | output | 1 | Completion interrupt request |
| irq_addr | output | 64 | Interrupt address |
| irq_data | output | 32 | Interrupt data |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_abort | input | 1 | Qualifies irq_ack: the delivery aborted |

## Verification
A wrong phase or status register shows at once on the command word. The very next read after a command write returns a code other than the expected one, and `job_start` pulses when it should not, or fails to pulse. If the validation is wrong, a refused descriptor still starts a job, or a legal one reads misconfigured within one cycle. A broken write lock shows up as a descriptor word or the command word changing during a job, which a read-back reveals. A broken interrupt path shows up as a missing or dropped `irq_req`, a final status that appears before the acknowledge, or a sticky abort bit that never sets.

// File: rtl/cmdframe_pkg.sv
package cmdframe_pkg;

    localparam logic [31:0] CODE_NOFRAME = 32'h0000_0000;
    localparam logic [31:0] CODE_HALT    = 32'h0000_0001;
    localparam logic [31:0] CODE_COPY    = 32'h0000_0002;
    localparam logic [31:0] CODE_FILL    = 32'h0000_0003;
    localparam logic [31:0] CODE_SUM     = 32'h0000_0004;
    localparam logic [31:0] CODE_MISCONF = 32'hFFFF_FFFE;
    localparam logic [31:0] CODE_ERROR   = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_RUN    = 2'd1,
        PH_NOTIFY = 2'd2
    } phase_e;

    // word addresses of the frame
    localparam int unsigned RA_CMD      = 0;
    localparam int unsigned RA_UCTRL    = 1;
    localparam int unsigned RA_LAUNCHED = 2;
    localparam int unsigned RA_RETURNED = 3;
    localparam int unsigned RA_IRQA_LO  = 4;
    localparam int unsigned RA_IRQA_HI  = 5;
    localparam int unsigned RA_IRQD     = 6;
    localparam int unsigned RA_SEED     = 7;
    localparam int unsigned RA_BEG_LO   = 8;
    localparam int unsigned RA_BEG_HI   = 9;
    localparam int unsigned RA_END_LO   = 10;
    localparam int unsigned RA_END_HI   = 11;
    localparam int unsigned RA_STR_LO   = 12;
    localparam int unsigned RA_STR_HI   = 13;
    localparam int unsigned RA_SUBS     = 14;

    typedef struct packed {
        logic [63:0] first;
        logic [63:0] last;
        logic [63:0] stride;
        logic [31:0] seed;
        logic [31:0] subs;
    } job_desc_t;

    function automatic logic is_job_code(input logic [31:0] c);
        return (c == CODE_COPY) || (c == CODE_FILL) || (c == CODE_SUM);
    endfunction

    function automatic logic stride_legal(input logic [63:0] s);
        return (s == 64'd1) || ((s != 64'd0) && (s[2:0] == 3'b000));
    endfunction

endpackage

// File: rtl/cmdframe_vet.sv
module cmdframe_vet
    import cmdframe_pkg::*;
#(
    parameter int unsigned SUBS_W = 20
) (
    input  logic [31:0] code,
    input  job_desc_t   desc,
    output logic        ok
);
    localparam int unsigned SUBS_TOP = 31;

    logic range_full;
    logic sum_misaligned;
    logic subs_bad;

    always_comb begin
        range_full     = (desc.first[63:3] == '0) && (desc.last[63:3] == '1);
        sum_misaligned = (code == CODE_SUM) &&
                         ((desc.first[2:0] != 3'b000) || (desc.last[2:0] != 3'b111));
        subs_bad       = (desc.subs != '1) && (desc.subs[SUBS_TOP:SUBS_W] != '0);
        ok             = is_job_code(code) && stride_legal(desc.stride) &&
                         !range_full && !sum_misaligned && !subs_bad;
    end

endmodule

// File: rtl/cmdframe_notify.sv
module cmdframe_notify (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic ack,
    input  logic abort,
    output logic req,
    output logic fin,
    output logic aborted
);
    always_ff @(posedge clk) begin
        if (rst)       req <= 1'b0;
        else if (fire) req <= 1'b1;
        else if (ack)  req <= 1'b0;
    end

    always_comb begin
        fin     = req && ack;
        aborted = req && ack && abort;
    end

endmodule

// File: rtl/cmdframe_ctrl.sv
module cmdframe_ctrl
    import cmdframe_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned SUBS_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              job_start,
    output logic [2:0]        job_op,
    output logic [63:0]       job_begin,
    output logic [63:0]       job_end,
    output logic [63:0]       job_stride,
    output logic [31:0]       job_seed,
    output logic [31:0]       job_substream,
    input  logic              txn_launch,
    input  logic              txn_return,
    input  logic              job_done,
    input  logic              job_abort,
    output logic              irq_req,
    output logic [63:0]       irq_addr,
    output logic [31:0]       irq_data,
    input  logic              irq_ack,
    input  logic              irq_abort
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    phase_e            phase_q;
    logic [31:0]       status_q;
    logic [31:0]       final_q;
    logic [31:0]       uctrl_q;
    logic [CNT_W-1:0]  launched_q;
    logic [CNT_W-1:0]  returned_q;
    logic [63:0]       irqa_q;
    logic [31:0]       irqd_q;
    job_desc_t         desc_q;
    logic              start_q;

    logic              wr_open;
    logic              vet_ok;
    logic              note_fire;
    logic              note_fin;
    logic              note_aborted;
    logic [31:0]       done_code;

    cmdframe_vet #(.SUBS_W(SUBS_W)) u_vet (
        .code (reg_wdata),
        .desc (desc_q),
        .ok   (vet_ok)
    );

    always_comb begin
        wr_open   = (phase_q == PH_IDLE);
        done_code = job_abort ? CODE_ERROR : CODE_HALT;
        note_fire = (phase_q == PH_RUN) && job_done && (irqa_q != 64'd0);
    end

    cmdframe_notify u_notify (
        .clk     (clk),
        .rst     (rst),
        .fire    (note_fire),
        .ack     (irq_ack),
        .abort   (irq_abort),
        .req     (irq_req),
        .fin     (note_fin),
        .aborted (note_aborted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            status_q   <= CODE_HALT;
            final_q    <= CODE_HALT;
            uctrl_q    <= '0;
            launched_q <= '0;
            returned_q <= '0;
            irqa_q     <= '0;
            irqd_q     <= '0;
            desc_q     <= '0;
            start_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (reg_wr) begin
                        case (reg_waddr)
                            ADDR_W'(RA_CMD): begin
                                if (reg_wdata == CODE_NOFRAME || reg_wdata == CODE_HALT) begin
                                    status_q <= CODE_HALT;
                                end else if (reg_wdata == CODE_MISCONF ||
                                             reg_wdata == CODE_ERROR) begin
                                    status_q <= reg_wdata;
                                end else if (vet_ok) begin
                                    status_q   <= reg_wdata;
                                    phase_q    <= PH_RUN;
                                    start_q    <= 1'b1;
                                    launched_q <= '0;
                                    returned_q <= '0;
                                end else begin
                                    status_q <= CODE_MISCONF;
                                end
                            end
                            ADDR_W'(RA_UCTRL):   uctrl_q             <= reg_wdata;
                            ADDR_W'(RA_IRQA_LO): irqa_q[31:0]        <= reg_wdata;
                            ADDR_W'(RA_IRQA_HI): irqa_q[63:32]       <= reg_wdata;
                            ADDR_W'(RA_IRQD):    irqd_q              <= reg_wdata;
                            ADDR_W'(RA_SEED):    desc_q.seed         <= reg_wdata;
                            ADDR_W'(RA_BEG_LO):  desc_q.first[31:0]  <= reg_wdata;
                            ADDR_W'(RA_BEG_HI):  desc_q.first[63:32] <= reg_wdata;
                            ADDR_W'(RA_END_LO):  desc_q.last[31:0]   <= reg_wdata;
                            ADDR_W'(RA_END_HI):  desc_q.last[63:32]  <= reg_wdata;
                            ADDR_W'(RA_STR_LO):  desc_q.stride[31:0] <= reg_wdata;
                            ADDR_W'(RA_STR_HI):  desc_q.stride[63:32] <= reg_wdata;
                            ADDR_W'(RA_SUBS):    desc_q.subs         <= reg_wdata;
                            default: ;
                        endcase
                    end
                end
                PH_RUN: begin
                    if (txn_launch) launched_q <= launched_q + CNT_ONE;
                    if (txn_return) returned_q <= returned_q + CNT_ONE;
                    if (job_done) begin
                        if (irqa_q != 64'd0) begin
                            final_q <= done_code;
                            phase_q <= PH_NOTIFY;
                        end else begin
                            status_q <= done_code;
                            phase_q  <= PH_IDLE;
                        end
                    end
                end
                PH_NOTIFY: begin
                    if (note_aborted) uctrl_q[0] <= 1'b1;
                    if (note_fin) begin
                        status_q <= final_q;
                        phase_q  <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        case (reg_raddr)
            ADDR_W'(RA_CMD):      reg_rdata = status_q;
            ADDR_W'(RA_UCTRL):    reg_rdata = uctrl_q;
            ADDR_W'(RA_LAUNCHED): reg_rdata = 32'(launched_q);
            ADDR_W'(RA_RETURNED): reg_rdata = 32'(returned_q);
            ADDR_W'(RA_IRQA_LO):  reg_rdata = irqa_q[31:0];
            ADDR_W'(RA_IRQA_HI):  reg_rdata = irqa_q[63:32];
            ADDR_W'(RA_IRQD):     reg_rdata = irqd_q;
            ADDR_W'(RA_SEED):     reg_rdata = desc_q.seed;
            ADDR_W'(RA_BEG_LO):   reg_rdata = desc_q.first[31:0];
            ADDR_W'(RA_BEG_HI):   reg_rdata = desc_q.first[63:32];
            ADDR_W'(RA_END_LO):   reg_rdata = desc_q.last[31:0];
            ADDR_W'(RA_END_HI):   reg_rdata = desc_q.last[63:32];
            ADDR_W'(RA_STR_LO):   reg_rdata = desc_q.stride[31:0];
            ADDR_W'(RA_STR_HI):   reg_rdata = desc_q.stride[63:32];
            ADDR_W'(RA_SUBS):     reg_rdata = desc_q.subs;
            default:              reg_rdata = 32'd0;
        endcase
    end

    always_comb begin
        job_start     = start_q;
        job_op        = status_q[2:0];
        job_begin     = desc_q.first;
        job_end       = desc_q.last;
        job_stride    = desc_q.stride;
        job_seed      = desc_q.seed;
        job_substream = desc_q.subs;
        irq_addr      = irqa_q;
        irq_data      = irqd_q;
    end

endmodule

// File: rtl/cmdframe_ctrl_chk.sv
module cmdframe_ctrl_chk
    import cmdframe_pkg::*;
#(
    parameter int unsigned SUBS_W = 20
) (
    input logic        clk,
    input logic        rst,
    input phase_e      phase_q,
    input logic [31:0] status_q,
    input logic        job_start,
    input logic [2:0]  job_op,
    input logic [63:0] job_begin,
    input logic [63:0] job_end,
    input logic [63:0] job_stride,
    input logic [31:0] job_substream,
    input logic        job_done,
    input logic        irq_req,
    input logic        irq_ack
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        job_start |=> !job_start); // R7

    AST_START_CODE: assert property (@(posedge clk) disable iff (rst)
        job_start |-> (phase_q == PH_RUN) && is_job_code(status_q)); // R7

    AST_START_STRIDE: assert property (@(posedge clk) disable iff (rst)
        job_start |-> (job_stride == 64'd1) ||
                      ((job_stride != 64'd0) && (job_stride[2:0] == 3'b000))); // R3

    AST_START_RANGE: assert property (@(posedge clk) disable iff (rst)
        job_start |-> !((job_begin[63:3] == '0) && (job_end[63:3] == '1))); // R4

    AST_SUM_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (job_start && job_op == 3'd4) |->
            (job_begin[2:0] == 3'b000) && (job_end[2:0] == 3'b111)); // R5

    AST_SUBS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        job_start |-> (job_substream == '1) || ((job_substream >> SUBS_W) == 32'd0)); // R6

    AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && !job_done) |=> $stable(status_q) && $stable(job_stride)); // R8

    AST_MISCONF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (status_q == CODE_MISCONF) |-> !irq_req && !job_start); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack) |=> irq_req); // R10

    AST_REQ_KEEPS_CODE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> is_job_code(status_q)); // R10

endmodule

bind cmdframe_ctrl cmdframe_ctrl_chk #(.SUBS_W(SUBS_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .phase_q       (phase_q),
    .status_q      (status_q),
    .job_start     (job_start),
    .job_op        (job_op),
    .job_begin     (job_begin),
    .job_end       (job_end),
    .job_stride    (job_stride),
    .job_substream (job_substream),
    .job_done      (job_done),
    .irq_req       (irq_req),
    .irq_ack       (irq_ack)
);

// File: tb/cmdframe_ctrl_tb.sv
module cmdframe_ctrl_tb;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_waddr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [AW-1:0] reg_raddr = '0;
    logic [31:0]   reg_rdata;
    logic          job_start;
    logic [2:0]    job_op;
    logic [63:0]   job_begin, job_end, job_stride;
    logic [31:0]   job_seed, job_substream;
    logic          txn_launch = 1'b0, txn_return = 1'b0;
    logic          job_done = 1'b0, job_abort = 1'b0;
    logic          irq_req;
    logic [63:0]   irq_addr;
    logic [31:0]   irq_data;
    logic          irq_ack = 1'b0, irq_abort = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int n_start  = 0;
    int n_irq    = 0;
    logic irq_prev = 1'b0;

    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    cmdframe_ctrl u_dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .job_start(job_start), .job_op(job_op), .job_begin(job_begin),
        .job_end(job_end), .job_stride(job_stride), .job_seed(job_seed),
        .job_substream(job_substream),
        .txn_launch(txn_launch), .txn_return(txn_return),
        .job_done(job_done), .job_abort(job_abort),
        .irq_req(irq_req), .irq_addr(irq_addr), .irq_data(irq_data),
        .irq_ack(irq_ack), .irq_abort(irq_abort)
    );

    // scoreboard monitor: pops the expected read value of this cycle
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) begin
                logic [31:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_checks++;
                if (reg_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: read %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    // event counters for start pulses and interrupt requests
    always @(negedge clk) begin
        if (!rst) begin
            if (job_start) n_start++;
            if (irq_req && !irq_prev) n_irq++;
            irq_prev <= irq_req;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_waddr = AW'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic wr64(input int a, input logic [63:0] d);
        wr(a, d[31:0]);
        wr(a + 1, d[63:32]);
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        reg_raddr = AW'(a);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(posedge clk); #1;
    endtask

    task automatic finish_job(input logic ab);
        job_done = 1'b1; job_abort = ab;
        @(posedge clk); #1;
        job_done = 1'b0; job_abort = 1'b0;
    endtask

    task automatic setup(input logic [63:0] b, input logic [63:0] e,
                         input logic [63:0] s, input logic [31:0] sub);
        wr64(8, b); wr64(10, e); wr64(12, s); wr(14, sub);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int s0, i0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(0, 32'h1, "R1 cmd after reset");
        rd(1, 32'h0, "R1 uctrl after reset");
        rd(2, 32'h0, "R1 launched after reset");
        rd(3, 32'h0, "R1 returned after reset");

        // R2 invalid code reads misconfigured on the next read
        s0 = n_start;
        wr(0, 32'h7);
        rd(0, 32'hFFFF_FFFE, "R2 invalid code 7");
        wr(0, 32'hFFFF_FFFD);
        rd(0, 32'hFFFF_FFFE, "R2 invalid code top");
        chk("R2 no start", 64'(n_start), 64'(s0));

        // R7 accepted copy command
        setup(64'h1000, 64'h10FF, 64'd8, 32'hFFFF_FFFF);
        wr(7, 32'hABCD);
        wr(0, 32'h2);
        chk("R7 start pulse", {63'd0, job_start}, 64'd1);
        chk("R7 begin out", job_begin, 64'h1000);
        chk("R7 seed out", {32'd0, job_seed}, {32'd0, 32'hABCD});
        rd(0, 32'h2, "R7 cmd shows running code");
        chk("R7 start one cycle", {63'd0, job_start}, 64'd0);

        // R8 writes ignored while running
        wr(12, 32'd5);
        wr(0, 32'h1);
        rd(12, 32'd8, "R8 stride unchanged");
        rd(0, 32'h2, "R8 cmd unchanged");

        // R12 counters
        txn_launch = 1'b1; txn_return = 1'b1;
        @(posedge clk); #1;
        txn_return = 1'b0;
        repeat (2) @(posedge clk); #1;
        txn_launch = 1'b0;
        rd(2, 32'd3, "R12 launched count");
        rd(3, 32'd1, "R12 returned count");

        // R9 success with no interrupt
        i0 = n_irq;
        finish_job(1'b0);
        rd(0, 32'h1, "R9 halted after success");
        chk("R9 no irq when address zero", 64'(n_irq), 64'(i0));

        // R3 stride rules
        wr64(12, 64'd0);
        wr(0, 32'h3);
        rd(0, 32'hFFFF_FFFE, "R3 stride 0 rejected");
        wr64(12, 64'd12);
        wr(0, 32'h3);
        rd(0, 32'hFFFF_FFFE, "R3 stride 12 rejected");
        wr64(12, 64'd1);
        s0 = n_start;
        wr(0, 32'h3);
        rd(0, 32'h3, "R3 stride 1 accepted");
        chk("R3 stride 1 started", 64'(n_start), 64'(s0 + 1));
        rd(2, 32'd0, "R12 counter cleared at start");
        finish_job(1'b1);
        rd(0, 32'hFFFF_FFFF, "R9 error after abort");

        // R5 sum alignment
        setup(64'h1004, 64'h10FF, 64'd8, 32'h0);
        wr(0, 32'h4);
        rd(0, 32'hFFFF_FFFE, "R5 misaligned begin");
        setup(64'h1000, 64'h10FE, 64'd8, 32'h0);
        wr(0, 32'h4);
        rd(0, 32'hFFFF_FFFE, "R5 misaligned end");
        setup(64'h1000, 64'h10FF, 64'd8, 32'h0);
        wr(0, 32'h4);
        rd(0, 32'h4, "R5 aligned sum accepted");
        finish_job(1'b0);

        // R4 full address space
        setup(64'h5, 64'hFFFF_FFFF_FFFF_FFF8, 64'd8, 32'h0);
        wr(0, 32'h2);
        rd(0, 32'hFFFF_FFFE, "R4 full range rejected");
        setup(64'h8, 64'hFFFF_FFFF_FFFF_FFF8, 64'd8, 32'h0);
        wr(0, 32'h2);
        rd(0, 32'h2, "R4 partial range accepted");
        finish_job(1'b0);

        // R6 substream width
        setup(64'h2000, 64'h20FF, 64'd1, 32'h0010_0000);
        wr(0, 32'h3);
        rd(0, 32'hFFFF_FFFE, "R6 substream 21 bits rejected");
        wr(14, 32'h000F_FFFF);
        wr(0, 32'h3);
        rd(0, 32'h3, "R6 substream 20 bits accepted");
        finish_job(1'b0);

        // R10 interrupt path with abort
        wr64(4, 64'h40);
        wr(6, 32'h77);
        wr(0, 32'h3);
        i0 = n_irq;
        finish_job(1'b0);
        chk("R10 irq_req raised", {63'd0, irq_req}, 64'd1);
        chk("R10 irq_addr", irq_addr, 64'h40);
        chk("R10 irq_data", {32'd0, irq_data}, 64'h77);
        rd(0, 32'h3, "R10 cmd held until ack");
        chk("R10 irq_req held", {63'd0, irq_req}, 64'd1);
        irq_ack = 1'b1; irq_abort = 1'b1;
        @(posedge clk); #1;
        irq_ack = 1'b0; irq_abort = 1'b0;
        chk("R10 irq_req dropped", {63'd0, irq_req}, 64'd0);
        rd(0, 32'h1, "R10 halted after ack");
        rd(1, 32'h1, "R10 abort sticky bit");
        chk("R10 one request", 64'(n_irq), 64'(i0 + 1));

        // R2 rejected command never interrupts, even with address set
        i0 = n_irq;
        wr64(12, 64'd3);
        wr(0, 32'h2);
        rd(0, 32'hFFFF_FFFE, "R2 reject with irq address");
        repeat (2) @(posedge clk); #1;
        chk("R2 no irq on reject", 64'(n_irq), 64'(i0));
        rd(1, 32'h1, "R10 sticky bit kept");

        // R11 no-frame code reads halted
        wr(0, 32'h0);
        rd(0, 32'h1, "R11 no-frame reads halted");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule